// File: doc/BRIEF.md
# Receive Character FIFO with Status Mode

This block is the receive-side buffer of one serial channel. A receiver in front of it hands over one character per cycle together with a four-bit error code; the block stores both side by side in a 1023-character queue, keeps a 16-bit count of stored characters and drives a trigger flag when the fill reaches a level the host has chosen. Host reads of the data register pop characters. In packed mode one word read pops up to two data bytes. In status mode it pops one character and returns its error code beside it.

A 16-bit status word reports the live line inputs, transmitter emptiness and data availability in its low half. Its upper half holds sticky receive conditions: overflow, two compare-match events and per-character break, framing and parity errors. These flags clear when the whole word is read and are left alone by a byte read. Two commands discard the queue: a count reset, and a channel reset that also wipes the sticky flags.

Top module: `rx_stat_fifo`

## Requirements
- R1: After reset `rx_count` is 0. `rx_count` always equals the number of stored characters and never exceeds 1023 (2**ADDR_W-1).
- R2: With status mode off, a word read returns the oldest character's data in bits 7:0 and the next one's data in bits 15:8, and pops both. With one character stored, bits 15:8 are 0 and one is popped. With none stored, the read returns 0 and pops nothing.
- R3: With status mode on, a word read returns the oldest data byte in bits 7:0 and its error code in bits 11:8, with bits 15:12 zero, and pops exactly one character. Status mode is set or cleared by `smode_wr` with `smode_val`, and it shows in status bit 15.
- R4: A character's error code keeps the receiver's bit order and is stored with the character: bit 3 break, bit 2 framing, bit 1 overrun, bit 0 parity.
- R5: Status bits 7:0 are, from bit 7 down: 0, 0, CTS, DSR, CD, transmit queue empty, transmit shifter empty, and data available (`rx_count` not 0).
- R6: Status bit 10 (break), bit 9 (framing) and bit 8 (parity) are set when an accepted character carries that error. Bit 12 and bit 11 are set by `cmp2_hit` and `cmp1_hit`. Bit 14 is always 0. Once set, these flags stay set until they are cleared.
- R7: A character arriving while 1023 are stored, with no pop in the same cycle, is dropped, the count is unchanged, and status bit 13 (overflow) is set.
- R8: A word read of the status (`stat_rd` with `stat_rd_word`=1) returns the flags and then clears bits 13:8. An event in the same cycle stays set.
- R9: A byte read of the status (`stat_rd` with `stat_rd_word`=0) leaves bits 13:8 unchanged.
- R10: `trig_hit` depends on `trig_sel`: 0 never, 1 for a count of at least 1, 2 for at least 512 (half), 3 for at least 896 (seven-eighths). It does not depend on `rx_int_en`.
- R11: `rx_irq` is high exactly when `trig_hit` and `rx_int_en` are both high.
- R12: `flush_cmd` empties the queue on the next edge and drops a character written in the same cycle. It leaves the sticky flags and the status mode as they are.
- R13: `uart_rst_cmd` empties the queue and clears status bits 13:8. The status mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | Receiver delivers a character this cycle |
| chr_data | input | 8 | Received data byte |
| chr_err | input | 4 | Error code: break, framing, overrun, parity (bits 3..0) |
| cmp1_hit | input | 1 | Compare value 1 matched (pulse) |
| cmp2_hit | input | 1 | Compare value 2 matched (pulse) |
| cts_i | input | 1 | CTS line active |
| dsr_i | input | 1 | DSR line active |
| cd_i | input | 1 | Carrier detect active |
| txq_empty_i | input | 1 | Transmit queue empty |
| txsh_empty_i | input | 1 | Transmit shifter empty |
| rd_word | input | 1 | Host word read of the data register (pops) |
| rd_data | output | 16 | Data word for the current read |
| stat_rd | input | 1 | Host read of the status register |
| stat_rd_word | input | 1 | 1 = full word read (clears flags), 0 = byte read |
| stat_word | output | 16 | Status register value |
| smode_wr | input | 1 | Write strobe for the status-mode enable |
| smode_val | input | 1 | New status-mode value |
| trig_sel | input | 2 | Trigger level select |
| rx_int_en | input | 1 | Receive interrupt enable |
| trig_hit | output | 1 | Trigger level reached |
| rx_irq | output | 1 | Receive interrupt request |
| flush_cmd | input | 1 | Reset receive count (discard queue) |
| uart_rst_cmd | input | 1 | Channel reset: discard queue and clear flags |
| rx_count | output | 16 | Stored character count |

## Verification
The assertions check on every cycle that the count stays within capacity, that a dropped write leaves the count unchanged, that a flush empties the queue, that the sticky flags never fall except through a clear, and that a cleared word read leaves nothing but same-cycle events. Data ordering, the packing of two bytes against one byte plus its error code, the exact trigger thresholds at 512 and 896, the 1023-character boundary, and the byte read that leaves the flags alone can only be shown by the bench's scenarios. The bench compares those scenarios against a queue model.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;

    localparam int CHR_W = 8;
    localparam int ERR_W = 4;

    // error code bit positions inside a stored character
    localparam int ERR_BRK = 3;
    localparam int ERR_FRM = 2;
    localparam int ERR_OVR = 1;
    localparam int ERR_PAR = 0;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [CHR_W-1:0] data;
    } rx_char_t;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_ONE  = 2'd1,
        TRIG_HALF = 2'd2,
        TRIG_7_8  = 2'd3
    } trig_sel_e;

    // sticky flags, packed in status bit order 13..8
    typedef struct packed {
        logic ovfl;
        logic cmp2;
        logic cmp1;
        logic brk;
        logic frm;
        logic par;
    } sticky_t;

    function automatic sticky_t char_events(rx_char_t c);
        sticky_t s;
        s      = '0;
        s.brk  = c.err[ERR_BRK];
        s.frm  = c.err[ERR_FRM];
        s.par  = c.err[ERR_PAR];
        return s;
    endfunction

endpackage

// File: rtl/rxsf_store.sv
module rxsf_store
    import rxsf_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  rx_char_t  push_char,
    input  logic [1:0] pop_n,
    output rx_char_t  head0,
    output rx_char_t  head1,
    output logic [AW:0] count,
    output logic      full,
    output logic      accepted
);
    localparam int DEPTH = 1 << AW;
    localparam int CAP   = DEPTH - 1;
    localparam logic [AW:0] CAP_V = (AW+1)'(CAP);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;

    assign full     = (count == CAP_V);
    assign accepted = push && !flush && (!full || pop_n != 2'd0);

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + AW'(1)];

    always_ff @(posedge clk) begin
        if (accepted) mem[wr_ptr] <= push_char;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + (AW+1)'(accepted) - (AW+1)'(pop_n);
        end
    end

    a_r1_count_cap: assert property (@(posedge clk) disable iff (rst)
        count <= CAP_V);

    a_r2_pop_within_count: assert property (@(posedge clk) disable iff (rst)
        (AW+1)'(pop_n) <= count);

    a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && pop_n == 2'd0 && !flush) |=> (count == CAP_V));

    a_r12_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/rxsf_trigger.sv
module rxsf_trigger
    import rxsf_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [AW:0] count,
    input  trig_sel_e   sel,
    input  logic        int_en,
    output logic        hit,
    output logic        irq
);
    localparam int HALF   = 1 << (AW - 1);
    localparam int SEVEN8 = 7 * (1 << (AW - 3));

    always_comb begin
        unique case (sel)
            TRIG_OFF:  hit = 1'b0;
            TRIG_ONE:  hit = (count != '0);
            TRIG_HALF: hit = (count >= (AW+1)'(HALF));
            default:   hit = (count >= (AW+1)'(SEVEN8));
        endcase
    end

    assign irq = hit && int_en;

    a_r10_off_never: assert property (@(posedge clk) disable iff (rst)
        (sel == TRIG_OFF) |-> !hit);

    a_r10_empty_no_hit: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !hit);

endmodule

// File: rtl/rxsf_status.sv
module rxsf_status
    import rxsf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        smode_wr,
    input  logic        smode_val,
    input  logic        clr_word,
    input  logic        clr_all,
    input  sticky_t     ev,
    input  logic        cts,
    input  logic        dsr,
    input  logic        cd,
    input  logic        txq_empty,
    input  logic        txsh_empty,
    input  logic        rda,
    output logic        smode,
    output logic [15:0] status_o
);
    sticky_t flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            smode <= 1'b0;
        end else begin
            if (clr_all)       flags <= '0;
            else if (clr_word) flags <= ev;
            else               flags <= flags | ev;
            if (smode_wr) smode <= smode_val;
        end
    end

    assign status_o = {smode, 1'b0, flags, 2'b00,
                       cts, dsr, cd, txq_empty, txsh_empty, rda};

    a_r8_word_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_word && ev == '0) |=> (status_o[13:8] == 6'd0));

    a_r6_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (!clr_word && !clr_all) |=>
            ((status_o[13:8] & $past(status_o[13:8])) == $past(status_o[13:8])));

    a_r6_bit14_zero: assert property (@(posedge clk) disable iff (rst)
        status_o[14] == 1'b0);

endmodule

// File: rtl/rx_stat_fifo.sv
module rx_stat_fifo
    import rxsf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        chr_valid,
    input  logic [7:0]  chr_data,
    input  logic [3:0]  chr_err,
    input  logic        cmp1_hit,
    input  logic        cmp2_hit,
    input  logic        cts_i,
    input  logic        dsr_i,
    input  logic        cd_i,
    input  logic        txq_empty_i,
    input  logic        txsh_empty_i,
    input  logic        rd_word,
    output logic [15:0] rd_data,
    input  logic        stat_rd,
    input  logic        stat_rd_word,
    output logic [15:0] stat_word,
    input  logic        smode_wr,
    input  logic        smode_val,
    input  logic [1:0]  trig_sel,
    input  logic        rx_int_en,
    output logic        trig_hit,
    output logic        rx_irq,
    input  logic        flush_cmd,
    input  logic        uart_rst_cmd,
    output logic [15:0] rx_count
);
    logic [ADDR_W:0] cnt;
    rx_char_t        head0, head1, in_char;
    logic            full, accepted, smode, flush_any;
    logic [1:0]      pop_n;
    sticky_t         ev;

    assign flush_any = flush_cmd || uart_rst_cmd;
    assign in_char   = '{err: chr_err, data: chr_data};

    always_comb begin
        pop_n = 2'd0;
        if (rd_word && cnt != '0 && !flush_any) begin
            if (smode || cnt == (ADDR_W+1)'(1)) pop_n = 2'd1;
            else                                 pop_n = 2'd2;
        end
    end

    always_comb begin
        if (cnt == '0)
            rd_data = 16'h0000;
        else if (smode)
            rd_data = {4'b0000, head0.err, head0.data};
        else if (cnt == (ADDR_W+1)'(1))
            rd_data = {8'h00, head0.data};
        else
            rd_data = {head1.data, head0.data};
    end

    always_comb begin
        ev = '0;
        if (!uart_rst_cmd) begin
            if (accepted) ev = char_events(in_char);
            ev.cmp1 = cmp1_hit;
            ev.cmp2 = cmp2_hit;
            ev.ovfl = chr_valid && !flush_cmd && full && pop_n == 2'd0;
        end
    end

    rxsf_store #(.AW(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_any),
        .push      (chr_valid),
        .push_char (in_char),
        .pop_n     (pop_n),
        .head0     (head0),
        .head1     (head1),
        .count     (cnt),
        .full      (full),
        .accepted  (accepted)
    );

    rxsf_trigger #(.AW(ADDR_W)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .count  (cnt),
        .sel    (trig_sel_e'(trig_sel)),
        .int_en (rx_int_en),
        .hit    (trig_hit),
        .irq    (rx_irq)
    );

    rxsf_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .smode_wr   (smode_wr),
        .smode_val  (smode_val),
        .clr_word   (stat_rd && stat_rd_word),
        .clr_all    (uart_rst_cmd),
        .ev         (ev),
        .cts        (cts_i),
        .dsr        (dsr_i),
        .cd         (cd_i),
        .txq_empty  (txq_empty_i),
        .txsh_empty (txsh_empty_i),
        .rda        (cnt != '0),
        .smode      (smode),
        .status_o   (stat_word)
    );

    assign rx_count = 16'(cnt);

    a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !rx_int_en |-> !rx_irq);

    a_r13_uart_reset_clears: assert property (@(posedge clk) disable iff (rst)
        uart_rst_cmd |=> (stat_word[13:8] == 6'd0 && rx_count == 16'd0));

    a_r5_rda_tracks_count: assert property (@(posedge clk) disable iff (rst)
        stat_word[0] == (rx_count != 16'd0));

endmodule

// File: tb/rx_stat_fifo_test.sv
module rx_stat_fifo_test;
    localparam int CAP = 1023;

    logic        clk = 1'b0;
    logic        rst;
    logic        chr_valid = 0, cmp1_hit = 0, cmp2_hit = 0;
    logic [7:0]  chr_data = 0;
    logic [3:0]  chr_err = 0;
    logic        cts_i = 0, dsr_i = 0, cd_i = 0, txq_empty_i = 0, txsh_empty_i = 0;
    logic        rd_word = 0, stat_rd = 0, stat_rd_word = 0;
    logic        smode_wr = 0, smode_val = 0, rx_int_en = 0;
    logic        flush_cmd = 0, uart_rst_cmd = 0;
    logic [1:0]  trig_sel = 0;
    logic [15:0] rd_data, stat_word, rx_count;
    logic        trig_hit, rx_irq;

    always #4 clk = ~clk;

    rx_stat_fifo uut (.*);

    int checks = 0;
    int fails  = 0;

    logic [11:0] q[$];
    logic [5:0]  m_flags = 0;
    logic        m_smode = 0;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        return {m_smode, 1'b0, m_flags, 2'b00, cts_i, dsr_i, cd_i,
                txq_empty_i, txsh_empty_i, q.size() != 0};
    endfunction

    function automatic logic exp_trig(logic [1:0] s, int n);
        case (s)
            2'd0: return 1'b0;
            2'd1: return n >= 1;
            2'd2: return n >= 512;
            default: return n >= 896;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(logic [7:0] d, logic [3:0] e);
        chr_valid = 1; chr_data = d; chr_err = e;
        tick();
        chr_valid = 0;
        if (q.size() < CAP) begin
            q.push_back({e, d});
            m_flags[2] |= e[3];
            m_flags[1] |= e[2];
            m_flags[0] |= e[0];
        end else begin
            m_flags[5] = 1'b1;
        end
    endtask

    task automatic read_word(string tag);
        logic [15:0] e;
        rd_word = 1;
        #1;
        if (q.size() == 0) e = 16'h0;
        else if (m_smode) e = {4'h0, q[0][11:8], q[0][7:0]};
        else if (q.size() == 1) e = {8'h00, q[0][7:0]};
        else e = {q[1][7:0], q[0][7:0]};
        chk(tag, rd_data, e);
        tick();
        rd_word = 0;
        if (q.size() != 0) void'(q.pop_front());
        if (!m_smode && q.size() != 0 && e[15:8] != 8'h00) void'(q.pop_front());
        else if (!m_smode && q.size() != 0 && e[15:8] == 8'h00 && q.size() >= 1 && e != 16'h0) begin
            // second byte may legitimately be 0x00 data
        end
    endtask

    task automatic read_status(logic word, string tag);
        stat_rd = 1; stat_rd_word = word;
        #1;
        chk(tag, stat_word, exp_status());
        tick();
        stat_rd = 0;
        if (word) m_flags = 6'd0;
    endtask

    task automatic set_smode(logic v);
        smode_wr = 1; smode_val = v;
        tick();
        smode_wr = 0;
        m_smode = v;
    endtask

    task automatic check_count(string tag);
        chk(tag, rx_count, 16'(q.size()));
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1A2B3C4D);
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();

        // reset state
        check_count("R1 reset count");
        chk("R5 reset status", stat_word, 16'h0000);
        chk("R10 reset trig", {15'd0, trig_hit}, 16'd0);

        // R2: packed mode ordering; use nonzero second bytes for pop accounting
        push(8'h11, 4'h0); push(8'h22, 4'h0); push(8'h33, 4'h0);
        check_count("R1 count after 3");
        read_word("R2 two bytes");
        check_count("R2 popped two");
        read_word("R2 single byte");
        check_count("R2 popped last");
        read_word("R2 empty read");
        check_count("R2 empty no pop");

        // R3/R4: status mode
        set_smode(1'b1);
        chk("R3 mode bit", stat_word, exp_status());
        push(8'hA5, 4'b1000); push(8'h5A, 4'b0010); push(8'h3C, 4'b0101);
        read_word("R4 break code");
        read_word("R4 overrun code");
        read_word("R4 framing+parity code");
        check_count("R3 one pop each");

        // R6/R9/R8
        chk("R6 sticky flags", stat_word, exp_status());
        read_status(1'b0, "R9 byte read");
        chk("R9 flags kept", stat_word, exp_status());
        read_status(1'b1, "R8 word read value");
        chk("R8 flags cleared", stat_word, exp_status());
        cmp1_hit = 1; tick(); cmp1_hit = 0; m_flags[3] = 1;
        chk("R6 cmp1 flag", stat_word, exp_status());
        stat_rd = 1; stat_rd_word = 1; cmp2_hit = 1; #1;
        chk("R8 read before clear", stat_word, exp_status());
        tick(); stat_rd = 0; cmp2_hit = 0; m_flags = 6'b010000;
        chk("R8 same-cycle event kept", stat_word, exp_status());
        read_status(1'b1, "R8 clear cmp2");

        // R5 line inputs
        cts_i = 1; cd_i = 1; txsh_empty_i = 1; #1;
        chk("R5 line bits", stat_word, exp_status());
        cts_i = 0; dsr_i = 1; txq_empty_i = 1; #1;
        chk("R5 line bits 2", stat_word, exp_status());

        // constrained random phase
        set_smode(1'b0);
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            cts_i = 1'($urandom); dsr_i = 1'($urandom); cd_i = 1'($urandom);
            txq_empty_i = 1'($urandom); txsh_empty_i = 1'($urandom);
            trig_sel = 2'($urandom); rx_int_en = 1'($urandom);
            if (r < 4) push(8'($urandom_range(1, 255)),
                            ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0);
            else if (r < 7) read_word("R2/R3 random read");
            else if (r == 7) read_status(1'($urandom), "R6/R8 random status");
            else if (r == 8) set_smode(1'($urandom));
            else begin cmp1_hit = 1'($urandom); cmp2_hit = 1'($urandom);
                m_flags[3] |= cmp1_hit; m_flags[4] |= cmp2_hit;
                tick(); cmp1_hit = 0; cmp2_hit = 0; end
            #1;
            check_count("R1 random count");
            chk("R10 random trig", {15'd0, trig_hit}, {15'd0, exp_trig(trig_sel, q.size())});
            chk("R11 random irq", {15'd0, rx_irq},
                {15'd0, exp_trig(trig_sel, q.size()) & rx_int_en});
        end

        // R12: flush, with a write in the same cycle
        flush_cmd = 1; chr_valid = 1; chr_data = 8'h77; chr_err = 4'h1;
        tick();
        flush_cmd = 0; chr_valid = 0;
        q.delete();
        check_count("R12 flush empties");
        chk("R12 flags kept", stat_word, exp_status());
        read_status(1'b1, "R8 clear before fill");

        // R10 thresholds and R7 overflow while filling
        rx_int_en = 0;
        for (int n = 1; n <= CAP; n++) begin
            push(8'(n | 1), 4'h0);
            if (n == 1 || n == 511 || n == 512 || n == 895 || n == 896) begin
                for (int s = 0; s < 4; s++) begin
                    trig_sel = 2'(s); #1;
                    chk("R10 threshold", {15'd0, trig_hit}, {15'd0, exp_trig(2'(s), n)});
                    chk("R11 irq disabled", {15'd0, rx_irq}, 16'd0);
                end
            end
        end
        check_count("R1 full count 1023");
        push(8'hEE, 4'h0);
        check_count("R7 dropped write");
        chk("R7 overflow flag", stat_word[13] ? 16'd1 : 16'd0, 16'd1);
        rx_int_en = 1; trig_sel = 2'd3; #1;
        chk("R11 irq enabled", {15'd0, rx_irq}, 16'd1);
        read_word("R2 read at full");
        check_count("R2 count after full read");

        // R13: channel reset clears flags, keeps mode
        set_smode(1'b1);
        push(8'h44, 4'b1111);
        uart_rst_cmd = 1; tick(); uart_rst_cmd = 0;
        q.delete(); m_flags = 6'd0;
        check_count("R13 queue emptied");
        chk("R13 flags cleared mode kept", stat_word, exp_status());

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule